// File: doc/BRIEF.md
# Framed Pixel Word Serial Link

This block moves 12-bit pixel words across a narrow two-lane link: one lane carries data, the other carries a forwarded strobe that changes level once for every bit placed on the data lane. The transmit half accepts a parallel word through a valid/ready handshake. It wraps the word in a low start bit and a high stop bit, and shifts the resulting 14-bit frame out one bit per strobe transition. Every bit is held for a programmable number of system clock cycles.

The receive half captures both lanes and treats each level change of the strobe lane as the moment to take one data bit. It finds a frame by its low start bit, gathers the payload and checks the stop bit. A good frame delivers the word with a one-cycle valid pulse. A bad stop bit raises a one-cycle framing-error pulse instead, and the word is discarded. Because the sampling instant travels with the data, no oversampling or clock recovery is needed. The two halves are joined only through the lane pins, so the lanes can be looped back or driven from elsewhere.

Top module: `pix_link`

## Requirements
- R1: During and after reset, with no word offered, the transmit data lane is 1, the transmit strobe lane is 0, `in_ready` is 1, and `out_valid` and `out_frame_err` are 0.
- R2: An accepted word is sent as 14 bits in this order: start bit 0, then payload bits 0 through 11 (least significant first), then stop bit 1. Each bit is held for BIT_DIV cycles. The strobe lane changes level exactly when a new bit is driven and at no other time.
- R3: `in_ready` is 0 while a frame is being sent. It returns to 1 only in the last cycle of the stop bit, and a word is taken only on a cycle where `in_valid` and `in_ready` are both 1.
- R4: When a new word is offered continuously, the next start bit directly follows the previous stop bit with no idle bit, so looped-back words arrive 14*BIT_DIV cycles apart.
- R5: In loopback, the received word appears on `out_data` with a one-cycle `out_valid` pulse exactly 13*BIT_DIV+2 clock cycles after the cycle in which it was accepted.
- R6: If the bit taken at the stop position is 0, `out_frame_err` pulses for one cycle, `out_valid` stays 0 and the word is dropped. The next correct frame is received normally.
- R7: The receiver takes data only on strobe-lane level changes. Data-lane changes while the strobe is steady are ignored, and a strobe change with data 1 while waiting for a frame does not start one.
- R8: After a frame ends with no new word offered, the data lane rests at 1 and the strobe lane stops changing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | PIX_W | Pixel word to send |
| in_valid | input | 1 | Pixel word offered |
| in_ready | output | 1 | Transmitter can take a word this cycle |
| tx_lane_dat | output | 1 | Transmit data lane |
| tx_lane_stb | output | 1 | Transmit forwarded strobe lane |
| rx_lane_dat | input | 1 | Receive data lane |
| rx_lane_stb | input | 1 | Receive forwarded strobe lane |
| out_data | output | PIX_W | Received pixel word |
| out_valid | output | 1 | One-cycle pulse, `out_data` holds a good word |
| out_frame_err | output | 1 | One-cycle pulse, stop bit was 0 and the word was dropped |

## Verification
The bench builds the block with PIX_W=12 and BIT_DIV=4. A short bit period keeps a frame to 56 cycles, so several words, a continuous back-to-back pair and exact latency counts fit easily in the run. The bench can switch the receive lanes from loopback to its own drivers. That lets it place a zero in the stop position, move the data lane without a strobe change, and send a lone idle strobe edge, none of which the transmitter would ever produce.

// File: rtl/pix_link_pkg.sv
package pix_link_pkg;
  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_BODY  = 2'd1,
    RX_CLOSE = 2'd2
  } rx_state_t;

  localparam logic LINE_REST = 1'b1;
  localparam logic MARK_OPEN = 1'b0;
  localparam logic MARK_SHUT = 1'b1;
endpackage

// File: rtl/pix_link_tx.sv
module pix_link_tx #(
  parameter int PIX_W   = 12,
  parameter int BIT_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] word_i,
  input  logic             word_vld_i,
  output logic             word_rdy_o,
  output logic             lane_dat_o,
  output logic             lane_stb_o
);
  import pix_link_pkg::*;

  localparam int FRAME_W = PIX_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int DIV_W   = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;

  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DIV_W-1:0]   div_cnt;
  logic               div_end;
  logic               last_bit;
  logic               take;

  assign div_end    = (div_cnt == DIV_W'(BIT_DIV - 1));
  assign last_bit   = (bit_cnt == CNT_W'(FRAME_W - 1));
  assign word_rdy_o = !busy || (last_bit && div_end);
  assign take       = word_vld_i && word_rdy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      shreg      <= '1;
      bit_cnt    <= '0;
      div_cnt    <= '0;
      lane_dat_o <= LINE_REST;
      lane_stb_o <= 1'b0;
    end else if (take) begin
      busy       <= 1'b1;
      shreg      <= {MARK_SHUT, word_i, MARK_OPEN};
      bit_cnt    <= '0;
      div_cnt    <= '0;
      lane_dat_o <= MARK_OPEN;
      lane_stb_o <= !lane_stb_o;
    end else if (busy) begin
      if (div_end) begin
        div_cnt <= '0;
        if (last_bit) begin
          busy       <= 1'b0;
          lane_dat_o <= LINE_REST;
        end else begin
          bit_cnt    <= bit_cnt + 1'b1;
          shreg      <= {1'b1, shreg[FRAME_W-1:1]};
          lane_dat_o <= shreg[1];
          lane_stb_o <= !lane_stb_o;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_link_lane_cap.sv
module pix_link_lane_cap (
  input  logic clk,
  input  logic rst,
  input  logic lane_dat_i,
  input  logic lane_stb_i,
  output logic bit_stb_o,
  output logic bit_val_o
);
  import pix_link_pkg::*;

  logic stb_q;
  logic stb_qq;
  logic dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= 1'b0;
      stb_qq <= 1'b0;
      dat_q  <= LINE_REST;
    end else begin
      stb_q  <= lane_stb_i;
      stb_qq <= stb_q;
      dat_q  <= lane_dat_i;
    end
  end

  assign bit_stb_o = stb_q ^ stb_qq;
  assign bit_val_o = dat_q;
endmodule

// File: rtl/pix_link_rx.sv
module pix_link_rx #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb_i,
  input  logic             bit_val_i,
  output logic [PIX_W-1:0] word_o,
  output logic             word_vld_o,
  output logic             frame_err_o
);
  import pix_link_pkg::*;

  localparam int CNT_W = $clog2(PIX_W);

  rx_state_t        state;
  logic [PIX_W-1:0] gather;
  logic [CNT_W-1:0] got_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= RX_WAIT;
      gather      <= '0;
      got_cnt     <= '0;
      word_o      <= '0;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      if (bit_stb_i) begin
        case (state)
          RX_WAIT: begin
            if (bit_val_i == MARK_OPEN) begin
              state   <= RX_BODY;
              got_cnt <= '0;
            end
          end
          RX_BODY: begin
            gather <= {bit_val_i, gather[PIX_W-1:1]};
            if (got_cnt == CNT_W'(PIX_W - 1)) begin
              state <= RX_CLOSE;
            end else begin
              got_cnt <= got_cnt + 1'b1;
            end
          end
          RX_CLOSE: begin
            state <= RX_WAIT;
            if (bit_val_i == MARK_SHUT) begin
              word_o     <= gather;
              word_vld_o <= 1'b1;
            end else begin
              frame_err_o <= 1'b1;
            end
          end
          default: state <= RX_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/pix_link.sv
module pix_link #(
  parameter int PIX_W   = 12,
  parameter int BIT_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             tx_lane_dat,
  output logic             tx_lane_stb,
  input  logic             rx_lane_dat,
  input  logic             rx_lane_stb,
  output logic [PIX_W-1:0] out_data,
  output logic             out_valid,
  output logic             out_frame_err
);
  logic cap_stb;
  logic cap_val;

  pix_link_tx #(.PIX_W(PIX_W), .BIT_DIV(BIT_DIV)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .word_i     (in_data),
    .word_vld_i (in_valid),
    .word_rdy_o (in_ready),
    .lane_dat_o (tx_lane_dat),
    .lane_stb_o (tx_lane_stb)
  );

  pix_link_lane_cap u_cap (
    .clk        (clk),
    .rst        (rst),
    .lane_dat_i (rx_lane_dat),
    .lane_stb_i (rx_lane_stb),
    .bit_stb_o  (cap_stb),
    .bit_val_o  (cap_val)
  );

  pix_link_rx #(.PIX_W(PIX_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .bit_stb_i   (cap_stb),
    .bit_val_i   (cap_val),
    .word_o      (out_data),
    .word_vld_o  (out_valid),
    .frame_err_o (out_frame_err)
  );
endmodule

// File: rtl/pix_link_chk.sv
module pix_link_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic tx_lane_dat,
  input logic tx_lane_stb,
  input logic out_valid,
  input logic out_frame_err
);
  AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !tx_lane_dat); // R2
  AST_DAT_MOVES_WITH_STB: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_lane_dat) |-> !$stable(tx_lane_stb)); // R2
  AST_READY_LANE_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_lane_dat); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_frame_err |=> !out_frame_err); // R6
  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    !(out_frame_err && out_valid)); // R6
endmodule

bind pix_link pix_link_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .tx_lane_dat   (tx_lane_dat),
  .tx_lane_stb   (tx_lane_stb),
  .out_valid     (out_valid),
  .out_frame_err (out_frame_err)
);

// File: tb/pix_link_tb.sv
`timescale 1ns/1ps
module pix_link_tb;
  localparam int PIX_W = 12;
  localparam int D     = 4;
  localparam int NVEC  = 6;
  // stimulus word, expected received word
  localparam logic [23:0] VEC [NVEC] = '{
    {12'h001, 12'h001}, {12'h800, 12'h800}, {12'hA5C, 12'hA5C},
    {12'hFFF, 12'hFFF}, {12'h000, 12'h000}, {12'h3C6, 12'h3C6}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PIX_W-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, tx_lane_dat, tx_lane_stb;
  logic [PIX_W-1:0] out_data;
  logic out_valid, out_frame_err;
  logic use_inj = 1'b0;
  logic inj_dat = 1'b1;
  logic inj_stb = 1'b0;
  logic rx_dat, rx_stb;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int n_out = 0;
  int n_err = 0;
  int last_t = 0;
  int prev_t = 0;
  logic [PIX_W-1:0] last_d = '0;
  logic [PIX_W-1:0] prev_d = '0;

  always #2 clk = !clk;

  assign rx_dat = use_inj ? inj_dat : tx_lane_dat;
  assign rx_stb = use_inj ? inj_stb : tx_lane_stb;

  pix_link #(.PIX_W(PIX_W), .BIT_DIV(D)) u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_lane_dat(tx_lane_dat), .tx_lane_stb(tx_lane_stb),
    .rx_lane_dat(rx_dat), .rx_lane_stb(rx_stb), .out_data(out_data),
    .out_valid(out_valid), .out_frame_err(out_frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        prev_t <= last_t;
        prev_d <= last_d;
        last_t <= cyc;
        last_d <= out_data;
        n_out  <= n_out + 1;
      end
      if (out_frame_err) n_err <= n_err + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_probe(input logic [PIX_W-1:0] w, input logic [PIX_W-1:0] exp);
    logic [13:0] frame;
    logic stb_prev;
    frame = {1'b1, w, 1'b0};
    stb_prev = tx_lane_stb;
    @(negedge clk);
    in_data = w;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 14; k++) begin
      chk(tx_lane_dat == frame[k], "R2 lane bit", tx_lane_dat, frame[k]);
      chk(tx_lane_stb != stb_prev, "R2 strobe change", tx_lane_stb, !stb_prev);
      chk(in_ready == 1'b0, "R3 ready low in frame", in_ready, 0);
      stb_prev = tx_lane_stb;
      if (k < 13) begin
        for (int c = 1; c < D; c++) begin
          @(negedge clk);
          chk(tx_lane_stb == stb_prev, "R2 strobe steady in bit", tx_lane_stb, stb_prev);
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 not yet valid", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 valid at 13*D+2", out_valid, 1);
    chk(out_data == exp, "R5 word", out_data, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 valid one cycle", out_valid, 0);
  endtask

  task automatic inj_bit(input logic b);
    @(negedge clk);
    inj_dat = b;
    inj_stb = !inj_stb;
    repeat (D - 1) @(negedge clk);
  endtask

  task automatic inj_frame(input logic [PIX_W-1:0] w, input logic stop);
    inj_bit(1'b0);
    for (int k = 0; k < PIX_W; k++) inj_bit(w[k]);
    inj_bit(stop);
  endtask

  task automatic run_all();
    int base;
    int eb;
    logic s0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(tx_lane_dat == 1'b1, "R1 data lane in reset", tx_lane_dat, 1);
    chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_lane_dat == 1'b1 && tx_lane_stb == 1'b0, "R1 lanes idle", {tx_lane_dat, tx_lane_stb}, 2);
    chk(in_ready == 1'b1, "R1 ready idle", in_ready, 1);
    chk(out_valid == 1'b0 && out_frame_err == 1'b0, "R1 outputs quiet", {out_valid, out_frame_err}, 0);

    // R2 R3 R5 table walk in loopback
    for (int i = 0; i < NVEC; i++) begin
      send_probe(VEC[i][23:12], VEC[i][11:0]);
      repeat (D) @(negedge clk);
    end

    // R8 idle after a frame
    repeat (2 * D) @(negedge clk);
    s0 = tx_lane_stb;
    for (int c = 0; c < 3 * D; c++) begin
      @(negedge clk);
      chk(tx_lane_dat == 1'b1 && tx_lane_stb == s0, "R8 lane rest", {tx_lane_dat, tx_lane_stb}, {1'b1, s0});
    end

    // R4 back-to-back words
    base = n_out;
    @(negedge clk);
    in_data = 12'h123;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_data = 12'hC4E;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 20 * D && n_out < base + 2; c++) @(negedge clk);
    chk(n_out == base + 2, "R4 two words out", n_out - base, 2);
    chk(last_t - prev_t == 14 * D, "R4 spacing", last_t - prev_t, 14 * D);
    chk(prev_d == 12'h123 && last_d == 12'hC4E, "R4 words", {prev_d, last_d}, {12'h123, 12'hC4E});
    repeat (3 * D) @(negedge clk);

    // switch to injected lanes without a spurious strobe change
    @(negedge clk);
    inj_stb = tx_lane_stb;
    inj_dat = 1'b1;
    use_inj = 1'b1;
    repeat (3) @(negedge clk);

    // R6 bad stop bit
    base = n_out;
    eb = n_err;
    inj_frame(12'h5A3, 1'b0);
    repeat (4) @(negedge clk);
    chk(n_err == eb + 1, "R6 error pulse", n_err - eb, 1);
    chk(n_out == base, "R6 word dropped", n_out - base, 0);
    inj_frame(12'h5A3, 1'b1);
    repeat (4) @(negedge clk);
    chk(n_out == base + 1 && last_d == 12'h5A3, "R6 recovery word", last_d, 12'h5A3);
    chk(n_err == eb + 1, "R6 no extra error", n_err - eb, 1);

    // R7 data wiggle without strobe, idle strobe with data 1
    base = n_out;
    eb = n_err;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      inj_dat = !inj_dat;
    end
    inj_bit(1'b1);
    inj_frame(12'h0F1, 1'b1);
    repeat (4) @(negedge clk);
    chk(n_out == base + 1, "R7 one word only", n_out - base, 1);
    chk(last_d == 12'h0F1, "R7 word aligned", last_d, 12'h0F1);
    chk(n_err == eb, "R7 no error", n_err - eb, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule